// File: doc/BRIEF.md
# Upset-Detection Shift Chain with Quarter-Rate Capture Window

This block is a long register chain built as a structure for measuring single-event upsets. A serial bit stream enters at one end and moves one stage per enabled cycle of a fast clock. Each stage-to-stage path can carry an even number of inverter cells, so a transient striking that logic has a chance of being latched. The data arrives at the next stage uncomplemented.

A divide-by-four counter does two things. It produces a slow shift clock for the external tester. On every rising edge of that shift clock, it copies the last four stages of the chain into a 4-bit window. The tester samples the window against the forwarded clock. It compares what it sees with the stream it sent and records every flipped bit.

The stage enable can be on in every cycle, or it can run on alternate cycles. The enable is held by a single flop that has its own active-low clear. While that clear is held, the chain stops. The main reset clears the block at once and is released through a two-flop synchronizer.

Top module: `seu_shift_chain`

## Requirements
- R1: With `altMode`=0, a bit applied on `serialIn` at main-clock edge m reaches `window` bit j when the capture happens at edge m+CHAIN_LEN-j.
- R2: Each stage path holds 2·INV_PAIRS inverter cells, so the data is never complemented for any legal setting.
- R3: `shiftClk` has one quarter of the main clock rate and a 50% duty cycle. `window` loads only at the main-clock edge where `shiftClk` rises, exactly 4 edges apart, and holds its value between loads.
- R4: `window[0]` is the last chain stage, which holds the oldest bit. `window[3]` is the fourth stage from the end.
- R5: Driving `rstN` low clears the chain, the window, `shiftClk` and the enable at once, without waiting for a clock. After `rstN` rises, `shiftClk` first reads 1 after the 4th main-clock rising edge.
- R6: With the enable always on and an alternating 0/1 input, every captured window is 4'b0101 or 4'b1010.
- R7: With `altMode`=1, the chain advances on every other main-clock edge. A lone 1 inside a 0 stream then shows up in exactly two successive captures, each one-hot, and its index falls by 2 between them.
- R8: While `enRstN` is low, the chain does not advance in either mode. The window stays constant but `shiftClk` keeps running. After `enRstN` rises, shifting resumes.
- R9: With `altMode`=0 and `enRstN` high, the chain advances on every main-clock edge from the second edge after either reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main shift clock |
| rstN | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| enRstN | input | 1 | Active-low clear of the stage-enable flop |
| altMode | input | 1 | 1: enable on alternate cycles; 0: enable every cycle |
| serialIn | input | 1 | Serial data into the first stage |
| window | output | WIN_W | Last four chain bits, loaded at quarter rate |
| shiftClk | output | 1 | Quarter-rate clock forwarded with the window |

## Verification
The bench logs every input bit by main-clock edge. It checks each captured window against that log, with the chain length counted in. A design that dropped or added one stage, reversed the window bit order, or let the padding complement the data would miss on most captures. After reset release the bench counts edges up to the first shift-clock rise, which catches a synchronizer that is too short or too long. The freeze test runs longer than the chain length, so a cleared enable that still let the chain shift would put 1s into the window. A single bit injected in alternating mode must appear in two captures exactly two positions apart, which catches an enable that never skips or skips the wrong cycles.

// File: rtl/seu_chain_pkg.sv
package seu_chain_pkg;
  // strobes from the control section to the datapath
  typedef struct packed {
    logic advance;  // chain stages load this edge
    logic capture;  // window loads this edge
  } chain_stb_t;
endpackage

// File: rtl/seu_inv_cell.sv
module seu_inv_cell (
  input  logic a,
  output logic y
);
  // one explicit inverter, kept as its own instance so the hierarchy preserves it
  assign y = ~a;
endmodule

// File: rtl/seu_inv_pad.sv
module seu_inv_pad #(
  parameter int PAIRS = 4
) (
  input  logic din,
  output logic dout
);
  localparam int NINV = 2 * PAIRS;

  generate
    if (NINV == 0) begin : g_wire
      assign dout = din;
    end else begin : g_inv
      logic [NINV:0] node;
      assign node[0] = din;
      for (genvar k = 0; k < NINV; k++) begin : g_cell
        seu_inv_cell u_cell (.a(node[k]), .y(node[k+1]));
      end
      assign dout = node[NINV];
    end
  endgenerate
endmodule

// File: rtl/seu_chain_ctrl.sv
module seu_chain_ctrl
  import seu_chain_pkg::*;
#(
  parameter int WIN_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enRstN,
  input  logic       altMode,
  output logic       sysRstN,
  output chain_stb_t stb,
  output logic       shiftClk
);
  localparam int DIV_W = $clog2(WIN_W);
  localparam int HALF  = WIN_W / 2;

  // reset: asserted at once, released through the synchronizer
  logic [SYNC_STAGES-1:0] syncQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], 1'b1};
  end
  assign sysRstN = syncQ[SYNC_STAGES-1];

  // the single flop that drives the enable fanout
  logic enClrN;
  logic enQ;
  assign enClrN = sysRstN & enRstN;
  always_ff @(posedge clk or negedge enClrN) begin
    if (!enClrN)      enQ <= 1'b0;
    else if (altMode) enQ <= ~enQ;
    else              enQ <= 1'b1;
  end

  // quarter-rate divider; its top bit is the forwarded clock
  logic [DIV_W-1:0] divCnt;
  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) divCnt <= '0;
    else          divCnt <= divCnt + 1'b1;
  end
  assign shiftClk = divCnt[DIV_W-1];

  always_comb begin
    stb.advance = enQ;
    stb.capture = (divCnt == DIV_W'(HALF - 1));
  end
endmodule

// File: rtl/seu_chain_dp.sv
module seu_chain_dp
  import seu_chain_pkg::*;
#(
  parameter int CHAIN_LEN = 64,
  parameter int INV_PAIRS = 4,
  parameter int WIN_W     = 4
) (
  input  logic             clk,
  input  logic             sysRstN,
  input  chain_stb_t       stb,
  input  logic             serialIn,
  output logic [WIN_W-1:0] window
);
  logic [CHAIN_LEN-1:0] stageQ;
  logic [CHAIN_LEN-1:0] stageD;
  logic [WIN_W-1:0]     tailBits;

  generate
    for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_stage
      logic padIn;
      if (i == 0) begin : g_head
        assign padIn = serialIn;
      end else begin : g_link
        assign padIn = stageQ[i-1];
      end
      seu_inv_pad #(.PAIRS(INV_PAIRS)) u_pad (.din(padIn), .dout(stageD[i]));
    end
  endgenerate

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN)         stageQ <= '0;
    else if (stb.advance) stageQ <= stageD;
  end

  // bit 0 of the window is the last stage
  always_comb begin
    for (int j = 0; j < WIN_W; j++) tailBits[j] = stageQ[CHAIN_LEN-1-j];
  end

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN)         window <= '0;
    else if (stb.capture) window <= tailBits;
  end
endmodule

// File: rtl/seu_shift_chain.sv
module seu_shift_chain
  import seu_chain_pkg::*;
#(
  parameter int CHAIN_LEN   = 64,
  parameter int INV_PAIRS   = 4,
  parameter int WIN_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enRstN,
  input  logic             altMode,
  input  logic             serialIn,
  output logic [WIN_W-1:0] window,
  output logic             shiftClk
);
  logic       sysRstN;
  chain_stb_t stb;

  seu_chain_ctrl #(.WIN_W(WIN_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .enRstN(enRstN), .altMode(altMode),
    .sysRstN(sysRstN), .stb(stb), .shiftClk(shiftClk)
  );

  seu_chain_dp #(.CHAIN_LEN(CHAIN_LEN), .INV_PAIRS(INV_PAIRS), .WIN_W(WIN_W)) u_dp (
    .clk(clk), .sysRstN(sysRstN), .stb(stb), .serialIn(serialIn), .window(window)
  );
endmodule

// File: rtl/seu_chain_chk.sv
module seu_chain_chk
  import seu_chain_pkg::*;
#(
  parameter int WIN_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             enRstN,
  input logic             altMode,
  input logic [WIN_W-1:0] window,
  input logic             shiftClk,
  input logic             sysRstN,
  input chain_stb_t       stb
);
  AST_RESET_CLEARS: assert property (@(posedge clk) !rstN |-> (window == '0 && !shiftClk && !stb.advance)); // R5
  AST_RELEASE_SYNC: assert property (@(posedge clk) disable iff (!rstN) $rose(sysRstN) |-> $past(rstN)); // R5
  AST_ENRST_HOLDS_OFF: assert property (@(posedge clk) disable iff (!sysRstN) !enRstN |-> !stb.advance); // R8
  AST_ALT_SKIPS: assert property (@(posedge clk) disable iff (!sysRstN || !enRstN) (altMode && stb.advance) |=> !stb.advance); // R7
  AST_FULL_RATE: assert property (@(posedge clk) disable iff (!sysRstN || !enRstN) !altMode |=> stb.advance); // R9
  AST_CAPTURE_EDGE: assert property (@(posedge clk) disable iff (!sysRstN) stb.capture |=> $rose(shiftClk)); // R3
  AST_WINDOW_HOLDS: assert property (@(posedge clk) disable iff (!sysRstN) !stb.capture |=> $stable(window)); // R3
endmodule

bind seu_shift_chain seu_chain_chk #(.WIN_W(WIN_W)) u_chk (
  .clk(clk), .rstN(rstN), .enRstN(enRstN), .altMode(altMode),
  .window(window), .shiftClk(shiftClk), .sysRstN(sysRstN), .stb(stb)
);

// File: tb/sim_seu_shift_chain.sv
module sim_seu_shift_chain;
  localparam int LEN   = 48;
  localparam int PAIRS = 2;
  localparam int SYNC  = 2;
  localparam int VCYC  = LEN + 24;
  localparam int NVEC  = 7;
  // {pattern[15:0], kind[1:0], expected[3:0]}; kind 1 = exact, 2 = alternating, 0 = log only
  localparam logic [21:0] VEC [NVEC] = '{
    {16'h0000, 2'd1, 4'h0}, {16'hFFFF, 2'd1, 4'hF}, {16'hAAAA, 2'd2, 4'h0},
    {16'h5555, 2'd2, 4'h0}, {16'hCCCC, 2'd0, 4'h0}, {16'hF0F0, 2'd0, 4'h0},
    {16'h8421, 2'd0, 4'h0}
  };

  logic clk = 1'b0;
  logic rstN, enRstN, altMode, serialIn;
  logic [3:0] window;
  logic shiftClk;

  seu_shift_chain #(.CHAIN_LEN(LEN), .INV_PAIRS(PAIRS), .WIN_W(4), .SYNC_STAGES(SYNC)) u0 (
    .clk(clk), .rstN(rstN), .enRstN(enRstN), .altMode(altMode),
    .serialIn(serialIn), .window(window), .shiftClk(shiftClk)
  );

  always #10 clk = ~clk;

  int nChecks = 0, nFail = 0;
  int edgeN = 0;
  logic hist [4096];
  bit histChk = 0;
  bit capValid = 0;
  logic scPrev = 1'b0;
  int lastCapEdge = 0;
  logic [3:0] capWin = '0;
  event capEv;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  initial for (int i = 0; i < 4096; i++) hist[i] = 1'b0;

  always @(posedge clk) begin
    edgeN = edgeN + 1;
    hist[edgeN & 4095] = serialIn;
  end

  // capture monitor: a capture happened at edge edgeN when shiftClk has just risen
  always @(negedge clk) begin
    if (!rstN) begin
      capValid = 0;
      scPrev = 1'b0;
    end else begin
      if (shiftClk && !scPrev) begin
        if (capValid) check(edgeN - lastCapEdge == 4, "R3 capture spacing", edgeN - lastCapEdge, 4);
        if (histChk && edgeN >= LEN + 4) begin
          logic [3:0] expW;
          for (int j = 0; j < 4; j++) expW[j] = hist[(edgeN - LEN + j) & 4095];
          check(window == expW, "R1 R2 R4 R9 delayed stream", window, expW);
        end
        capValid = 1;
        lastCapEdge = edgeN;
        capWin = window;
        -> capEv;
      end else if (capValid && window != capWin) begin
        check(0, "R3 window held between loads", window, capWin);
      end
      scPrev = shiftClk;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitCaps(input int n);
    repeat (n) @(capEv);
  endtask

  task automatic releaseCheck();
    int first = 0;
    rstN = 1'b1;
    for (int k = 1; k <= 8; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (shiftClk && first == 0) first = k;
    end
    check(first == SYNC + 2, "R5 release latency", first, SYNC + 2);
  endtask

  initial begin
    #(64'd20 * 200000);
    nFail++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [3:0] w0, w1, w2;
    int hits, i1, i2;
    rstN = 1'b1; enRstN = 1'b1; altMode = 1'b0; serialIn = 1'b0;
    #2 rstN = 1'b0;
    cyc(5);
    check(window == 4'h0 && !shiftClk, "R5 reset state", {window, shiftClk}, 0);
    releaseCheck();
    cyc(8);

    // vector table, full-rate enable, every capture checked against the input log
    histChk = 1;
    for (int v = 0; v < NVEC; v++) begin
      logic [15:0] pat;
      logic [1:0] kind;
      logic [3:0] expW;
      pat = VEC[v][21:6]; kind = VEC[v][5:4]; expW = VEC[v][3:0];
      for (int k = 0; k < VCYC; k++) begin
        serialIn = pat[k % 16];
        @(negedge clk);
      end
      if (kind == 2'd1) check(capWin == expW, "R1 constant pattern", capWin, expW);
      if (kind == 2'd2) check(capWin == 4'b0101 || capWin == 4'b1010, "R6 checkerboard", capWin, 4'b0101);
    end
    histChk = 0;

    // R8: freeze longer than the chain, then resume
    for (int k = 0; k < LEN + 8; k++) begin serialIn = k[0]; cyc(1); end
    enRstN = 1'b0;
    waitCaps(2);
    w0 = capWin;
    serialIn = 1'b1;
    for (int k = 0; k < 16; k++) begin
      waitCaps(1);
      check(capWin == w0, "R8 frozen window", capWin, w0);
    end
    @(negedge clk);
    enRstN = 1'b1;
    cyc(LEN + 12);
    waitCaps(1);
    check(capWin == 4'hF, "R8 resume after enable clear", capWin, 4'hF);

    // R7: lone bit in alternating mode
    @(negedge clk);
    altMode = 1'b1; serialIn = 1'b0;
    cyc(2 * LEN + 16);
    serialIn = 1'b1;
    cyc(2);
    serialIn = 1'b0;
    hits = 0; w1 = '0; w2 = '0;
    for (int k = 0; k < (2 * LEN + 40) / 4; k++) begin
      waitCaps(1);
      if (capWin != 4'h0) begin
        if (hits == 0) w1 = capWin; else w2 = capWin;
        hits++;
      end
    end
    check(hits == 2, "R7 captures holding the bit", hits, 2);
    check($onehot(w1) && $onehot(w2), "R7 one-hot windows", {w1, w2}, 8'h00);
    i1 = 0; i2 = 0;
    for (int j = 0; j < 4; j++) begin
      if (w1[j]) i1 = j;
      if (w2[j]) i2 = j;
    end
    check(i1 - i2 == 2, "R7 index step", i1 - i2, 2);

    // R5: asynchronous clear mid-run
    @(negedge clk);
    altMode = 1'b0; serialIn = 1'b1;
    cyc(LEN + 12);
    check(window == 4'hF, "R9 full window before reset", window, 4'hF);
    #3 rstN = 1'b0;
    #1 check(window == 4'h0 && !shiftClk, "R5 asynchronous clear", {window, shiftClk}, 0);
    serialIn = 1'b0;
    cyc(3);
    releaseCheck();
    cyc(4);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule